// File: doc/BRIEF.md
# Complementary PWM Deadtime Inserter

The block turns one PWM reference into a complementary pair of outputs, A and B. A follows the reference's high phase and B follows its low phase. A falling output drops one clock after the reference level is sampled. A rising output is held back by a programmed deadtime, so both outputs stay low for that interval. Two 16-bit delay words are used: one sets the deadtime on A's rising edge, the other sets it on B's rising edge.

A mode input selects how the delay words are read. With fractional mode off, each word is a whole number of clock cycles. With fractional mode on, the upper bits are whole cycles and the low five bits are a fraction in 1/32 steps. The block does not produce the fraction itself. It issues the 5-bit code together with a one-cycle strobe, in the same cycle as the delayed edge, so that an external fine-delay element can place that edge. The reference may already carry sub-cycle edge placement. The pair stays complementary with deadtime in that case, because only the sampled reference level is used.

Top module: `pwm_deadtime_pair`

## Requirements
- R1: While synchronous reset `rst` is high, and in the first cycle after it, `outA`, `outB`, `fracStrobe` and `fracCode` are all zero.
- R2: `outA` and `outB` are never high in the same cycle.
- R3: When `refIn` is sampled at a clock edge, the output of the opposite phase is low after that edge (B low after 1 is sampled, A low after 0 is sampled).
- R4: Let edge k be the first clock edge that samples `refIn` at 1 after it was 0. `outA` goes high after edge k+N, where N is the whole-cycle count taken from `dtRiseA`.
- R5: Let edge k be the first clock edge that samples `refIn` at 0 after it was 1. `outB` goes high after edge k+N, where N is the whole-cycle count taken from `dtRiseB`.
- R6: With `fracMode`=0, N is bits [10:0] of the delay word (0 to 2047), and bits [15:11] have no effect.
- R7: With `fracMode`=1, N is bits [15:5] of the delay word. The same whole deadtime as in non-fractional mode is therefore the value shifted left by 5.
- R8: With `fracMode`=1, `fracStrobe` is high for exactly the one cycle in which the delayed output rises, and `fracCode` then equals bits [4:0] of that output's delay word. In every other cycle, and always when `fracMode`=0, `fracStrobe` is 0 and `fracCode` is 0.
- R9: If `refIn` changes again before a deadtime count ends, the pending rising edge is cancelled and the count restarts for the other output.
- R10: A whole count of 0 makes the output rise after edge k itself, one cycle after the reference change.
- R11: The first edge after reset treats the sampled `refIn` level as a new edge, so the matching output rises after its deadtime even if the reference never toggles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| refIn | input | 1 | PWM reference level |
| fracMode | input | 1 | 1 = delay words carry a 5-bit fraction |
| dtRiseA | input | 16 | Deadtime word for the rising edge of A |
| dtRiseB | input | 16 | Deadtime word for the rising edge of B |
| outA | output | 1 | Phase output A |
| outB | output | 1 | Complementary phase output B |
| fracCode | output | 5 | Sub-cycle fraction for the edge rising now |
| fracStrobe | output | 1 | One-cycle marker for a fractional edge |

## Verification
The bench builds the block with its default 16-bit delay word and 5-bit fraction, so the whole count is 11 bits wide. This brings the extreme counts within reach: 0xFFFF in both modes gives 2047 whole cycles, and 31/32 is exported in fractional mode. Words with bits set above bit 10 show, at the outputs, that those bits are ignored when fractional mode is off. The same widths let directed runs cover cancellation of a pending edge, the zero-count path and the first edge out of reset.

// File: rtl/pwm_dt_pkg.sv
package pwm_dt_pkg;
  // Strobes passed from the timing control to the output datapath.
  typedef struct packed {
    logic dropA;   // force A low now
    logic dropB;   // force B low now
    logic riseA;   // raise A now
    logic riseB;   // raise B now
    logic capA;    // hold A's fraction for a later rise
    logic capB;    // hold B's fraction for a later rise
    logic immed;   // rise happens on the edge itself (zero count)
  } dtStrobes_t;
endpackage

// File: rtl/pwm_dt_ctrl.sv
module pwm_dt_ctrl
  import pwm_dt_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refIn,
  input  logic [CNT_W-1:0] wholeA,
  input  logic [CNT_W-1:0] wholeB,
  output dtStrobes_t       strb
);
  logic             refQ, armed, pending, tgtA;
  logic [CNT_W-1:0] cnt;
  logic             edgeSeen;
  logic [CNT_W-1:0] loadVal;

  assign edgeSeen = !armed || (refIn != refQ);
  assign loadVal  = refIn ? wholeA : wholeB;

  always_comb begin
    strb = '0;
    if (edgeSeen) begin
      if (refIn) begin
        strb.dropB = 1'b1;
        if (wholeA == '0) begin
          strb.riseA = 1'b1;
          strb.immed = 1'b1;
        end else begin
          strb.capA = 1'b1;
        end
      end else begin
        strb.dropA = 1'b1;
        if (wholeB == '0) begin
          strb.riseB = 1'b1;
          strb.immed = 1'b1;
        end else begin
          strb.capB = 1'b1;
        end
      end
    end else if (pending && cnt == CNT_W'(1)) begin
      strb.riseA = tgtA;
      strb.riseB = !tgtA;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      refQ    <= 1'b0;
      armed   <= 1'b0;
      pending <= 1'b0;
      tgtA    <= 1'b0;
      cnt     <= '0;
    end else begin
      refQ  <= refIn;
      armed <= 1'b1;
      if (edgeSeen) begin
        tgtA    <= refIn;
        cnt     <= loadVal;
        pending <= (loadVal != '0);
      end else if (pending) begin
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) pending <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwm_dt_datapath.sv
module pwm_dt_datapath
  import pwm_dt_pkg::*;
#(
  parameter int DT_W   = 16,
  parameter int FRAC_W = 5,
  localparam int WHOLE_W = DT_W - FRAC_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fracMode,
  input  logic [DT_W-1:0]    dtRiseA,
  input  logic [DT_W-1:0]    dtRiseB,
  input  dtStrobes_t         strb,
  output logic [WHOLE_W-1:0] wholeA,
  output logic [WHOLE_W-1:0] wholeB,
  output logic               outA,
  output logic               outB,
  output logic [FRAC_W-1:0]  fracCode,
  output logic               fracStrobe
);
  logic [DT_W-1:0]    dtWord  [2];
  logic [WHOLE_W-1:0] wholeCh [2];
  logic [FRAC_W-1:0]  fracCh  [2];
  logic [FRAC_W-1:0]  fracHold;
  logic               fire;

  assign dtWord[0] = dtRiseA;
  assign dtWord[1] = dtRiseB;

  for (genvar ch = 0; ch < 2; ch++) begin : g_decode
    assign wholeCh[ch] = fracMode ? dtWord[ch][DT_W-1:FRAC_W]
                                  : dtWord[ch][WHOLE_W-1:0];
    assign fracCh[ch]  = fracMode ? dtWord[ch][FRAC_W-1:0] : '0;
  end

  assign wholeA = wholeCh[0];
  assign wholeB = wholeCh[1];
  assign fire   = strb.riseA || strb.riseB;

  always_ff @(posedge clk) begin
    if (rst) begin
      outA       <= 1'b0;
      outB       <= 1'b0;
      fracHold   <= '0;
      fracCode   <= '0;
      fracStrobe <= 1'b0;
    end else begin
      if (strb.dropA)      outA <= 1'b0;
      else if (strb.riseA) outA <= 1'b1;
      if (strb.dropB)      outB <= 1'b0;
      else if (strb.riseB) outB <= 1'b1;
      if (strb.capA) fracHold <= fracCh[0];
      if (strb.capB) fracHold <= fracCh[1];
      fracStrobe <= fire && fracMode;
      if (fire && fracMode)
        fracCode <= strb.immed ? (strb.riseA ? fracCh[0] : fracCh[1]) : fracHold;
      else
        fracCode <= '0;
    end
  end
endmodule

// File: rtl/pwm_deadtime_pair.sv
module pwm_deadtime_pair
  import pwm_dt_pkg::*;
#(
  parameter int DT_W   = 16,
  parameter int FRAC_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              refIn,
  input  logic              fracMode,
  input  logic [DT_W-1:0]   dtRiseA,
  input  logic [DT_W-1:0]   dtRiseB,
  output logic              outA,
  output logic              outB,
  output logic [FRAC_W-1:0] fracCode,
  output logic              fracStrobe
);
  localparam int WHOLE_W = DT_W - FRAC_W;

  dtStrobes_t         strb;
  logic [WHOLE_W-1:0] wholeA, wholeB;

  pwm_dt_ctrl #(.CNT_W(WHOLE_W)) ctrl_i (
    .clk(clk), .rst(rst), .refIn(refIn),
    .wholeA(wholeA), .wholeB(wholeB), .strb(strb)
  );

  pwm_dt_datapath #(.DT_W(DT_W), .FRAC_W(FRAC_W)) dp_i (
    .clk(clk), .rst(rst), .fracMode(fracMode),
    .dtRiseA(dtRiseA), .dtRiseB(dtRiseB), .strb(strb),
    .wholeA(wholeA), .wholeB(wholeB),
    .outA(outA), .outB(outB), .fracCode(fracCode), .fracStrobe(fracStrobe)
  );
endmodule

// File: rtl/pwm_dt_checker.sv
module pwm_dt_checker #(
  parameter int FRAC_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              refIn,
  input logic              fracMode,
  input logic              outA,
  input logic              outB,
  input logic [FRAC_W-1:0] fracCode,
  input logic              fracStrobe
);
  // R2
  a_r2_never_both_high: assert property (@(posedge clk) disable iff (rst)
    !(outA && outB));
  // R3
  a_r3_a_low_after_ref_low: assert property (@(posedge clk) disable iff (rst)
    !refIn |=> !outA);
  a_r3_b_low_after_ref_high: assert property (@(posedge clk) disable iff (rst)
    refIn |=> !outB);
  // R8
  a_r8_no_strobe_integer_mode: assert property (@(posedge clk) disable iff (rst)
    !fracMode |=> !fracStrobe);
  a_r8_code_zero_off_strobe: assert property (@(posedge clk) disable iff (rst)
    !fracStrobe |-> fracCode == '0);
  a_r8_strobe_one_cycle: assert property (@(posedge clk) disable iff (rst)
    fracStrobe |=> !fracStrobe);
  // R1
  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!outA && !outB && !fracStrobe));
endmodule

bind pwm_deadtime_pair pwm_dt_checker #(.FRAC_W(FRAC_W)) chk_i (
  .clk(clk), .rst(rst), .refIn(refIn), .fracMode(fracMode),
  .outA(outA), .outB(outB), .fracCode(fracCode), .fracStrobe(fracStrobe)
);

// File: tb/pwm_deadtime_pair_tb_top.sv
`timescale 1ns/1ps
module pwm_deadtime_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        refIn, fracMode;
  logic [15:0] dtRiseA, dtRiseB;
  logic        outA, outB, fracStrobe;
  logic [4:0]  fracCode;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  pwm_deadtime_pair dut_i (
    .clk(clk), .rst(rst), .refIn(refIn), .fracMode(fracMode),
    .dtRiseA(dtRiseA), .dtRiseB(dtRiseB),
    .outA(outA), .outB(outB), .fracCode(fracCode), .fracStrobe(fracStrobe)
  );

  // {fracMode, dtRiseA, dtRiseB}
  localparam logic [32:0] VECS [7] = '{
    {1'b0, 16'h0003, 16'h0005},   // R4 R5 plain counts
    {1'b0, 16'h0000, 16'h0000},   // R10 zero counts
    {1'b0, 16'hF804, 16'h0802},   // R6 upper bits ignored
    {1'b1, 16'h0067, 16'h005F},   // R7 R8 whole 3 frac 7, whole 2 frac 31
    {1'b1, 16'h0011, 16'h0020},   // R10 R8 whole 0 frac 17, whole 1 frac 0
    {1'b0, 16'h07FF, 16'h0001},   // R6 max integer count
    {1'b1, 16'hFFFF, 16'h0040}    // R7 max fractional count
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int wholeOf(input logic m, input logic [15:0] w);
    return m ? int'(w[15:5]) : int'(w[10:0]);
  endfunction

  // Drive refIn at a negedge and time the rise of the selected output.
  task automatic riseTest(input bit isA, input int expCyc, input int expCode,
                          input bit expStb, input string tag);
    int cyc = 0;
    bit seen = 0;
    bit bad = 0;
    int code = 0;
    bit stb = 0;
    refIn = isA;
    while (!seen && cyc < 3000) begin
      @(posedge clk); #1;
      cyc++;
      if (outA && outB) bad = 1;
      if (cyc == 1) check(isA ? !outB : !outA, {tag, " R3 opposite low"},
                          isA ? int'(outB) : int'(outA), 0);
      if (isA ? outA : outB) begin
        seen = 1;
        code = fracCode;
        stb  = fracStrobe;
      end else if (fracStrobe || fracCode != 0) bad = 1;
    end
    check(cyc == expCyc, {tag, " rise cycle R4/R5"}, cyc, expCyc);
    check(code == expCode, {tag, " R8 code"}, code, expCode);
    check(stb == expStb, {tag, " R8 strobe"}, stb, expStb);
    check(!bad, {tag, " R2/R8 interim"}, bad, 0);
    @(posedge clk); #1;
    check(!fracStrobe && fracCode == 0, {tag, " R8 strobe one cycle"}, fracStrobe, 0);
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; refIn = 1'b1; fracMode = 1'b0;
    dtRiseA = 16'd4; dtRiseB = 16'd2;
    repeat (3) @(posedge clk);
    #1;
    check(!outA && !outB && !fracStrobe && fracCode == 0, "R1 reset state",
          {outA, outB, fracStrobe}, 0);
    // R11: first edge after reset with ref low, B count 2 -> rises after 3 observations
    @(negedge clk);
    refIn = 1'b0;
    rst = 1'b0;
    riseTest(1'b0, 3, 0, 1'b0, "R11 first edge");

    for (int i = 0; i < 7; i++) begin
      fracMode = VECS[i][32];
      dtRiseA  = VECS[i][31:16];
      dtRiseB  = VECS[i][15:0];
      riseTest(1'b1, wholeOf(fracMode, dtRiseA) + 1,
               fracMode ? int'(dtRiseA[4:0]) : 0, fracMode, $sformatf("vec%0d A", i));
      riseTest(1'b0, wholeOf(fracMode, dtRiseB) + 1,
               fracMode ? int'(dtRiseB[4:0]) : 0, fracMode, $sformatf("vec%0d B", i));
    end

    // R9: cancel a pending A rise by toggling back early
    fracMode = 1'b0; dtRiseA = 16'd10; dtRiseB = 16'd4;
    refIn = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      check(!outA && !outB, "R9 both low during deadtime", {outA, outB}, 0);
    end
    @(negedge clk);
    riseTest(1'b0, 5, 0, 1'b0, "R9 restart for B");
    for (int c = 0; c < 12; c++) begin
      @(posedge clk); #1;
      check(!outA && outB, "R9 cancelled A stays low", {outA, outB}, 1);
    end
    @(negedge clk);

    // R6: change of ignored upper bits while integer mode has no effect on timing
    dtRiseA = 16'hA802;
    riseTest(1'b1, 3, 0, 1'b0, "R6 ignored bits");

    // R1: reset mid-run pulls outputs low
    rst = 1'b1;
    @(posedge clk); #1;
    check(!outA && !outB, "R1 reset mid-run", {outA, outB}, 0);
    rst = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule